// File: doc/BRIEF.md
# Peer Setup Message Sequencer

This block sits between a byte channel from a coordination server and the logic that wires up shared-memory doorbells between peers. The server sends a series of 64-bit signed little-endian messages, one byte at a time and in chunks of any size. A sideband flag says whether the message carries an attached handle. The block rebuilds each message and checks the opening handshake: first a protocol version, then the identity assigned to this device. After that it tracks which peers have registered how many interrupt vectors.

Connect messages carry no vector number. The sequencer infers the vector from how many connects that peer has already sent. When the peer is this device itself, it pulses a strobe that tells local logic to prepare that vector. The setup phase ends only when the shared-memory message arrives. Any error during setup leaves the block in a failed state. After setup the same decoding continues in run mode, where errors are reported as pulses and the block keeps running.

Top module: `peer_setup_seq`

## Requirements
- R1: A message is 8 bytes taken on cycles with `in_valid` high, least significant byte first. Idle cycles may fall between bytes. The handle flag is sampled only with the eighth byte.
- R2: The first message must equal `PROTO_VER` (default 0) and carry no handle. Otherwise the block enters the failed state with error code 1.
- R3: The second message must carry no handle and lie in 0..65535. It then becomes `own_id`. Otherwise the block fails with code 2.
- R4: When `cfg_master` is 1, the assigned ID must be 0. Otherwise the block fails with code 3.
- R5: After the ID, a message value below -1 or above 65535 gives code 4.
- R6: The value -1 raises `setup_done` the first time it arrives. A later -1 gives code 5.
- R7: A connect is a non-negative value with a handle. It raises the named peer's count by one. If the peer is `own_id`, `vec_setup_stb` pulses for one cycle with `vec_setup_idx` equal to the count before the increment.
- R8: A connect for a peer whose count is already at least `cfg_max_vec` gives code 6 and leaves the count unchanged.
- R9: A disconnect is a non-negative value without a handle. It clears the peer's count to zero. It gives code 7 when it names `own_id` or a peer at or above `tbl_size`. Any peer index at or above `MAX_PEERS` also gives code 7.
- R10: `tbl_size` is `INIT_PEERS` (16) after reset. A connect naming peer p with p >= `tbl_size` sets it to p+1.
- R11: After reset, `setup_done`, `setup_fail`, `own_id`, `err_code`, all counts and all strobes are zero.
- R12: Once failed, the block ignores further messages: no count change, no strobe, no error pulse.
- R13: Any error detected pulses `err_stb` for one cycle and updates `err_code`. During setup the error also sets `setup_fail`. In run mode `setup_done` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A message byte is present |
| in_byte | input | 8 | Message byte |
| in_handle | input | 1 | Handle attached (sampled with the last byte) |
| cfg_max_vec | input | VEC_W | Vector limit per peer (normally 1) |
| cfg_master | input | 1 | Device must be assigned ID 0 |
| own_id | output | 16 | Assigned identity |
| setup_done | output | 1 | Shared-memory message received, run mode |
| setup_fail | output | 1 | Setup aborted by an error |
| tbl_size | output | SIZE_W | Current peer table size |
| qry_peer | input | PEER_W | Peer whose count is shown |
| qry_count | output | VEC_W | Vector count of `qry_peer` |
| vec_setup_stb | output | 1 | Prepare a local interrupt vector |
| vec_setup_idx | output | VEC_W | Vector to prepare |
| err_stb | output | 1 | Error pulse |
| err_code | output | 3 | Code of the most recent error |

## Verification
On every cycle, the assertions check these properties:
- the failed state is sticky, and so is run mode;
- the two states never coincide;
- a master that has finished setup holds ID 0;
- the table size stays within its bounds;
- strobes and error pulses only follow a completed message;
- a setup strobe never names a vector at or beyond the limit, and never coincides with an error.

The bench scenarios are needed for the rest:
- the little-endian byte order across gaps;
- vector numbering from the connect count;
- which error code each malformed message yields;
- table growth;
- silence after a failure.

// File: rtl/peer_seq_pkg.sv
package peer_seq_pkg;

  typedef enum logic [2:0] {
    ST_VER  = 3'd0,
    ST_ID   = 3'd1,
    ST_SHM  = 3'd2,
    ST_RUN  = 3'd3,
    ST_FAIL = 3'd4
  } seq_state_e;

  typedef enum logic [2:0] {
    E_NONE     = 3'd0,
    E_VERSION  = 3'd1,
    E_ID       = 3'd2,
    E_MASTER   = 3'd3,
    E_RANGE    = 3'd4,
    E_DUP_SHM  = 3'd5,
    E_VEC_FULL = 3'd6,
    E_PEER     = 3'd7
  } seq_err_e;

  localparam int MSG_BYTES = 8;
  localparam logic signed [63:0] ID_LIMIT = 64'sd65535;

endpackage

// File: rtl/msg_assembler.sv
module msg_assembler
  import peer_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  input  logic        in_handle,
  output logic        msg_vld,
  output logic [63:0] msg_data,
  output logic        msg_hdl
);

  localparam int CNT_W = $clog2(MSG_BYTES);
  localparam int BUF_W = 8 * (MSG_BYTES - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MSG_BYTES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BUF_W-1:0] buf_q, buf_d;
  logic             vld_q, vld_d;
  logic [63:0]      data_q, data_d;
  logic             hdl_q, hdl_d;

  always_comb begin
    cnt_d  = cnt_q;
    buf_d  = buf_q;
    vld_d  = 1'b0;
    data_d = data_q;
    hdl_d  = hdl_q;
    if (in_valid) begin
      if (cnt_q == LAST) begin
        vld_d  = 1'b1;
        data_d = {in_byte, buf_q};
        hdl_d  = in_handle;
        cnt_d  = '0;
      end else begin
        buf_d[{cnt_q, 3'b000} +: 8] = in_byte;
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      buf_q  <= '0;
      vld_q  <= 1'b0;
      data_q <= '0;
      hdl_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (in_valid) begin
        cnt_q  <= cnt_d;
        buf_q  <= buf_d;
        data_q <= data_d;
        hdl_q  <= hdl_d;
      end
    end
  end

  assign msg_vld  = vld_q;
  assign msg_data = data_q;
  assign msg_hdl  = hdl_q;

endmodule

// File: rtl/peer_vec_table.sv
module peer_vec_table #(
  parameter int MAX_PEERS  = 32,
  parameter int INIT_PEERS = 16,
  parameter int VEC_W      = 4,
  localparam int PEER_W    = $clog2(MAX_PEERS),
  localparam int SIZE_W    = $clog2(MAX_PEERS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PEER_W-1:0] upd_idx,
  input  logic              inc_en,
  input  logic              clr_en,
  input  logic              grow_en,
  input  logic [PEER_W-1:0] qry_idx,
  output logic [VEC_W-1:0]  upd_cnt,
  output logic [VEC_W-1:0]  qry_cnt,
  output logic [SIZE_W-1:0] size
);

  logic [VEC_W-1:0]  cnt_q [MAX_PEERS];
  logic [VEC_W-1:0]  cnt_d [MAX_PEERS];
  logic [SIZE_W-1:0] size_q, size_d;
  logic              tbl_en;

  for (genvar g = 0; g < MAX_PEERS; g++) begin : g_entry
    logic hit;
    assign hit = (upd_idx == PEER_W'(g));
    assign cnt_d[g] = (clr_en && hit) ? '0 :
                      (inc_en && hit) ? cnt_q[g] + 1'b1 : cnt_q[g];
  end

  always_comb begin
    size_d = size_q;
    if (grow_en && (SIZE_W'(upd_idx) >= size_q))
      size_d = SIZE_W'(upd_idx) + 1'b1;
  end

  assign tbl_en = inc_en | clr_en | grow_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= SIZE_W'(INIT_PEERS);
      for (int i = 0; i < MAX_PEERS; i++) cnt_q[i] <= '0;
    end else if (tbl_en) begin
      size_q <= size_d;
      for (int i = 0; i < MAX_PEERS; i++) cnt_q[i] <= cnt_d[i];
    end
  end

  assign upd_cnt = cnt_q[upd_idx];
  assign qry_cnt = cnt_q[qry_idx];
  assign size    = size_q;

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import peer_seq_pkg::*;
#(
  parameter int MAX_PEERS = 32,
  parameter int VEC_W     = 4,
  parameter logic signed [63:0] PROTO_VER = 64'sd0,
  localparam int PEER_W   = $clog2(MAX_PEERS),
  localparam int SIZE_W   = $clog2(MAX_PEERS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_vld,
  input  logic [63:0]       msg_data,
  input  logic              msg_hdl,
  input  logic [VEC_W-1:0]  cfg_max_vec,
  input  logic              cfg_master,
  input  logic [VEC_W-1:0]  peer_cnt,
  input  logic [SIZE_W-1:0] tbl_size,
  output logic [PEER_W-1:0] peer_idx,
  output logic              inc_en,
  output logic              clr_en,
  output logic              grow_en,
  output logic [15:0]       own_id,
  output logic              setup_done,
  output logic              setup_fail,
  output logic              vec_stb,
  output logic [VEC_W-1:0]  vec_idx,
  output logic              err_stb,
  output logic [2:0]        err_code
);

  seq_state_e        st_q, st_d;
  logic [15:0]       own_q, own_d;
  logic              vstb_q, vstb_d;
  logic [VEC_W-1:0]  vidx_q, vidx_d;
  logic              estb_q, estb_d;
  seq_err_e          code_q, code_d;
  seq_err_e          err;

  logic signed [63:0] sval;
  logic [15:0]        peer16;
  logic               is_shm, bad_range, id_ok, in_cap, beyond_tbl, is_own;

  assign sval       = signed'(msg_data);
  assign peer16     = msg_data[15:0];
  assign is_shm     = (sval == -64'sd1);
  assign bad_range  = (sval < -64'sd1) || (sval > ID_LIMIT);
  assign id_ok      = (sval >= 64'sd0) && (sval <= ID_LIMIT);
  assign in_cap     = (peer16 < 16'(MAX_PEERS));
  assign beyond_tbl = (peer16 >= 16'(tbl_size));
  assign is_own     = (peer16 == own_q);
  assign peer_idx   = msg_data[PEER_W-1:0];

  always_comb begin
    st_d    = st_q;
    own_d   = own_q;
    vstb_d  = 1'b0;
    vidx_d  = vidx_q;
    estb_d  = 1'b0;
    code_d  = code_q;
    inc_en  = 1'b0;
    clr_en  = 1'b0;
    grow_en = 1'b0;
    err     = E_NONE;
    if (msg_vld) begin
      unique case (st_q)
        ST_VER: begin
          if (msg_hdl || (sval != PROTO_VER)) err = E_VERSION;
          else st_d = ST_ID;
        end
        ST_ID: begin
          if (msg_hdl || !id_ok) err = E_ID;
          else if (cfg_master && (peer16 != 16'd0)) err = E_MASTER;
          else begin
            own_d = peer16;
            st_d  = ST_SHM;
          end
        end
        ST_SHM, ST_RUN: begin
          if (bad_range) err = E_RANGE;
          else if (is_shm) begin
            if (st_q == ST_RUN) err = E_DUP_SHM;
            else st_d = ST_RUN;
          end else if (!in_cap) err = E_PEER;
          else if (msg_hdl) begin
            grow_en = 1'b1;
            if (peer_cnt >= cfg_max_vec) err = E_VEC_FULL;
            else begin
              inc_en = 1'b1;
              if (is_own) begin
                vstb_d = 1'b1;
                vidx_d = peer_cnt;
              end
            end
          end else begin
            if (is_own || beyond_tbl) err = E_PEER;
            else clr_en = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (err != E_NONE) begin
      estb_d = 1'b1;
      code_d = err;
      if (st_q != ST_RUN) st_d = ST_FAIL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_VER;
      own_q  <= '0;
      vstb_q <= 1'b0;
      vidx_q <= '0;
      estb_q <= 1'b0;
      code_q <= E_NONE;
    end else begin
      vstb_q <= vstb_d;
      estb_q <= estb_d;
      if (msg_vld) begin
        st_q   <= st_d;
        own_q  <= own_d;
        vidx_q <= vidx_d;
        code_q <= code_d;
      end
    end
  end

  assign own_id     = own_q;
  assign setup_done = (st_q == ST_RUN);
  assign setup_fail = (st_q == ST_FAIL);
  assign vec_stb    = vstb_q;
  assign vec_idx    = vidx_q;
  assign err_stb    = estb_q;
  assign err_code   = code_q;

endmodule

// File: rtl/peer_setup_seq.sv
module peer_setup_seq #(
  parameter int MAX_PEERS  = 32,
  parameter int INIT_PEERS = 16,
  parameter int VEC_W      = 4,
  parameter logic signed [63:0] PROTO_VER = 64'sd0,
  localparam int PEER_W    = $clog2(MAX_PEERS),
  localparam int SIZE_W    = $clog2(MAX_PEERS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              in_handle,
  input  logic [VEC_W-1:0]  cfg_max_vec,
  input  logic              cfg_master,
  output logic [15:0]       own_id,
  output logic              setup_done,
  output logic              setup_fail,
  output logic [SIZE_W-1:0] tbl_size,
  input  logic [PEER_W-1:0] qry_peer,
  output logic [VEC_W-1:0]  qry_count,
  output logic              vec_setup_stb,
  output logic [VEC_W-1:0]  vec_setup_idx,
  output logic              err_stb,
  output logic [2:0]        err_code
);

  logic              msg_vld;
  logic [63:0]       msg_data;
  logic              msg_hdl;
  logic [PEER_W-1:0] peer_idx;
  logic              inc_en, clr_en, grow_en;
  logic [VEC_W-1:0]  peer_cnt;

  msg_assembler u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .in_handle(in_handle),
    .msg_vld  (msg_vld),
    .msg_data (msg_data),
    .msg_hdl  (msg_hdl)
  );

  seq_ctrl #(
    .MAX_PEERS(MAX_PEERS),
    .VEC_W    (VEC_W),
    .PROTO_VER(PROTO_VER)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_vld    (msg_vld),
    .msg_data   (msg_data),
    .msg_hdl    (msg_hdl),
    .cfg_max_vec(cfg_max_vec),
    .cfg_master (cfg_master),
    .peer_cnt   (peer_cnt),
    .tbl_size   (tbl_size),
    .peer_idx   (peer_idx),
    .inc_en     (inc_en),
    .clr_en     (clr_en),
    .grow_en    (grow_en),
    .own_id     (own_id),
    .setup_done (setup_done),
    .setup_fail (setup_fail),
    .vec_stb    (vec_setup_stb),
    .vec_idx    (vec_setup_idx),
    .err_stb    (err_stb),
    .err_code   (err_code)
  );

  peer_vec_table #(
    .MAX_PEERS (MAX_PEERS),
    .INIT_PEERS(INIT_PEERS),
    .VEC_W     (VEC_W)
  ) u_tbl (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_idx(peer_idx),
    .inc_en (inc_en),
    .clr_en (clr_en),
    .grow_en(grow_en),
    .qry_idx(qry_peer),
    .upd_cnt(peer_cnt),
    .qry_cnt(qry_count),
    .size   (tbl_size)
  );

endmodule

// File: rtl/peer_setup_seq_chk.sv
module peer_setup_seq_chk #(
  parameter int MAX_PEERS  = 32,
  parameter int INIT_PEERS = 16,
  parameter int VEC_W      = 4,
  localparam int SIZE_W    = $clog2(MAX_PEERS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_vld,
  input logic [VEC_W-1:0]  cfg_max_vec,
  input logic              cfg_master,
  input logic [15:0]       own_id,
  input logic              setup_done,
  input logic              setup_fail,
  input logic [SIZE_W-1:0] tbl_size,
  input logic              vec_setup_stb,
  input logic [VEC_W-1:0]  vec_setup_idx,
  input logic              err_stb
);

  p_fail_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    setup_fail |=> setup_fail);

  p_run_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
    setup_done |=> setup_done);

  p_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(setup_done && setup_fail));

  p_done_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(setup_done) |-> $past(msg_vld));

  p_err_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
    err_stb |-> $past(msg_vld));

  p_stb_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_setup_stb |-> $past(msg_vld));

  p_stb_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_setup_stb |-> (vec_setup_idx < $past(cfg_max_vec)));

  p_stb_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_setup_stb |-> !err_stb);

  p_master_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && setup_done) |-> (own_id == 16'd0));

  p_tbl_bounds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_size >= SIZE_W'(INIT_PEERS)) && (tbl_size <= SIZE_W'(MAX_PEERS)));

endmodule

bind peer_setup_seq peer_setup_seq_chk #(
  .MAX_PEERS (MAX_PEERS),
  .INIT_PEERS(INIT_PEERS),
  .VEC_W     (VEC_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .msg_vld      (msg_vld),
  .cfg_max_vec  (cfg_max_vec),
  .cfg_master   (cfg_master),
  .own_id       (own_id),
  .setup_done   (setup_done),
  .setup_fail   (setup_fail),
  .tbl_size     (tbl_size),
  .vec_setup_stb(vec_setup_stb),
  .vec_setup_idx(vec_setup_idx),
  .err_stb      (err_stb)
);

// File: tb/peer_setup_seq_tb.sv
module peer_setup_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_PEERS  = 32;
  localparam int VEC_W      = 4;
  localparam int PEER_W     = $clog2(MAX_PEERS);
  localparam int SIZE_W     = $clog2(MAX_PEERS + 1);
  localparam logic [63:0] SHM  = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] NEG2 = 64'hFFFF_FFFF_FFFF_FFFE;

  typedef struct packed {
    logic [63:0] val;
    logic        hdl;
    logic [4:0]  qp;
    logic [3:0]  qc;
    logic [2:0]  code;
    logic        stb;
    logic [3:0]  sidx;
    logic        done;
    logic [3:0]  req;
  } row_t;

  localparam int NROWS = 16;
  localparam row_t ROWS [NROWS] = '{
    '{64'd0,     1'b0, 5'd0,  4'd0, 3'd0, 1'b0, 4'd0, 1'b0, 4'd2},  // R2 version ok
    '{64'd2,     1'b0, 5'd0,  4'd0, 3'd0, 1'b0, 4'd0, 1'b0, 4'd3},  // R3 own id 2
    '{64'd0,     1'b1, 5'd0,  4'd1, 3'd0, 1'b0, 4'd0, 1'b0, 4'd7},  // R7 connect peer 0
    '{64'd2,     1'b1, 5'd2,  4'd1, 3'd0, 1'b1, 4'd0, 1'b0, 4'd7},  // R7 own vector 0
    '{64'd2,     1'b1, 5'd2,  4'd2, 3'd0, 1'b1, 4'd1, 1'b0, 4'd7},  // R7 own vector 1
    '{SHM,       1'b0, 5'd2,  4'd2, 3'd0, 1'b0, 4'd0, 1'b1, 4'd6},  // R6 setup done
    '{64'd2,     1'b1, 5'd2,  4'd2, 3'd6, 1'b0, 4'd0, 1'b1, 4'd8},  // R8 vectors full
    '{SHM,       1'b0, 5'd2,  4'd2, 3'd5, 1'b0, 4'd0, 1'b1, 4'd6},  // R6 second shm
    '{64'd20,    1'b1, 5'd20, 4'd1, 3'd0, 1'b0, 4'd0, 1'b1, 4'd10}, // R10 grow
    '{64'd0,     1'b0, 5'd0,  4'd0, 3'd0, 1'b0, 4'd0, 1'b1, 4'd9},  // R9 disconnect
    '{64'd2,     1'b0, 5'd2,  4'd2, 3'd7, 1'b0, 4'd0, 1'b1, 4'd9},  // R9 own disconnect
    '{64'd25,    1'b0, 5'd25, 4'd0, 3'd7, 1'b0, 4'd0, 1'b1, 4'd9},  // R9 beyond table
    '{NEG2,      1'b0, 5'd0,  4'd0, 3'd4, 1'b0, 4'd0, 1'b1, 4'd5},  // R5 below -1
    '{64'd65536, 1'b1, 5'd0,  4'd0, 3'd4, 1'b0, 4'd0, 1'b1, 4'd5},  // R5 above 65535
    '{64'd40,    1'b1, 5'd0,  4'd0, 3'd7, 1'b0, 4'd0, 1'b1, 4'd9},  // R9 beyond capacity
    '{64'd1,     1'b1, 5'd1,  4'd1, 3'd0, 1'b0, 4'd0, 1'b1, 4'd13}  // R13 still running
  };

  logic              clk, rst_n;
  logic              in_valid, in_handle, cfg_master;
  logic [7:0]        in_byte;
  logic [VEC_W-1:0]  cfg_max_vec;
  logic [15:0]       own_id;
  logic              setup_done, setup_fail;
  logic [SIZE_W-1:0] tbl_size;
  logic [PEER_W-1:0] qry_peer;
  logic [VEC_W-1:0]  qry_count;
  logic              vec_setup_stb, err_stb;
  logic [VEC_W-1:0]  vec_setup_idx;
  logic [2:0]        err_code;

  int n_chk, n_bad, n_err, n_stb, last_code, last_idx;
  bit finished;

  peer_setup_seq #(.MAX_PEERS(MAX_PEERS), .VEC_W(VEC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_handle(in_handle), .cfg_max_vec(cfg_max_vec), .cfg_master(cfg_master),
    .own_id(own_id), .setup_done(setup_done), .setup_fail(setup_fail),
    .tbl_size(tbl_size), .qry_peer(qry_peer), .qry_count(qry_count),
    .vec_setup_stb(vec_setup_stb), .vec_setup_idx(vec_setup_idx),
    .err_stb(err_stb), .err_code(err_code)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (err_stb) begin n_err++; last_code = int'(err_code); end
      if (vec_setup_stb) begin n_stb++; last_idx = int'(vec_setup_idx); end
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic do_reset(input logic master);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_byte = '0; in_handle = 1'b0;
    cfg_master = master;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // handle is driven inverted on the first seven bytes so only the last counts
  task automatic send_msg(input logic [63:0] v, input logic h, input int gap);
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte = v[8*b +: 8];
      in_handle = (b == 7) ? h : ~h;
      if (gap > 0 && b < 7) begin
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int e0, s0;
    n_chk = 0; n_bad = 0; n_err = 0; n_stb = 0; last_code = 0; last_idx = 0;
    finished = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_byte = '0; in_handle = 1'b0;
    cfg_master = 1'b0; cfg_max_vec = 4'd2; qry_peer = '0;

    // R11 reset state
    do_reset(1'b0);
    check("R11 done", setup_done, 0);
    check("R11 fail", setup_fail, 0);
    check("R11 own_id", own_id, 0);
    check("R11 err_code", err_code, 0);
    check("R11 count", qry_count, 0);
    check("R10 initial size", tbl_size, 16);

    // table walk
    for (int i = 0; i < NROWS; i++) begin
      row_t r;
      string tag;
      r = ROWS[i];
      tag = $sformatf("R%0d row%0d", r.req, i);
      qry_peer = r.qp;
      e0 = n_err; s0 = n_stb;
      send_msg(r.val, r.hdl, i % 3);
      check({tag, " err pulses"}, n_err - e0, (r.code != 0) ? 1 : 0);
      if (r.code != 0) check({tag, " err code"}, last_code, r.code);
      check({tag, " strobes"}, n_stb - s0, r.stb);
      if (r.stb) check({tag, " vec idx"}, last_idx, r.sidx);
      check({tag, " count"}, qry_count, r.qc);
      check({tag, " done"}, setup_done, r.done);
    end
    check("R10 grown size", tbl_size, 21);
    check("R13 no fail in run", setup_fail, 0);
    check("R3 own id", own_id, 2);

    // R1 chunked bytes, little-endian
    do_reset(1'b0);
    send_msg(64'd0, 1'b0, 2);
    send_msg(64'h0102, 1'b0, 3);
    check("R1 byte order own_id", own_id, 16'h0102);
    check("R1 no fail", setup_fail, 0);

    // R2 version mismatch, then R12 ignore
    do_reset(1'b0);
    e0 = n_err;
    send_msg(64'd7, 1'b0, 0);
    check("R2 fail", setup_fail, 1);
    check("R2 code", last_code, 1);
    check("R13 pulse", n_err - e0, 1);
    qry_peer = 5'd0;
    e0 = n_err; s0 = n_stb;
    send_msg(64'd0, 1'b1, 0);
    send_msg(SHM, 1'b0, 0);
    check("R12 count", qry_count, 0);
    check("R12 no err", n_err - e0, 0);
    check("R12 no strobe", n_stb - s0, 0);
    check("R12 not done", setup_done, 0);

    // R2 version with handle
    do_reset(1'b0);
    send_msg(64'd0, 1'b1, 0);
    check("R2 handle fail", setup_fail, 1);

    // R3 id carrying a handle
    do_reset(1'b0);
    send_msg(64'd0, 1'b0, 0);
    send_msg(64'd4, 1'b1, 0);
    check("R3 fail", setup_fail, 1);
    check("R3 code", last_code, 2);

    // R3 id out of range
    do_reset(1'b0);
    send_msg(64'd0, 1'b0, 0);
    send_msg(64'd65536, 1'b0, 0);
    check("R3 range code", last_code, 2);

    // R4 master with nonzero id
    do_reset(1'b1);
    send_msg(64'd0, 1'b0, 0);
    send_msg(64'd3, 1'b0, 0);
    check("R4 fail", setup_fail, 1);
    check("R4 code", last_code, 3);

    // R4 master with id 0
    do_reset(1'b1);
    send_msg(64'd0, 1'b0, 0);
    send_msg(64'd0, 1'b0, 0);
    send_msg(SHM, 1'b0, 0);
    check("R4 ok done", setup_done, 1);
    check("R4 ok fail", setup_fail, 0);

    // R5 bad value during setup
    do_reset(1'b0);
    send_msg(64'd0, 1'b0, 0);
    send_msg(64'd1, 1'b0, 0);
    send_msg(64'hFFFF_FFFF_FFFF_FFF7, 1'b0, 0);
    check("R5 setup fail", setup_fail, 1);
    check("R5 setup code", last_code, 4);

    // R8 with limit 1 during setup
    cfg_max_vec = 4'd1;
    do_reset(1'b0);
    send_msg(64'd0, 1'b0, 0);
    send_msg(64'd1, 1'b0, 0);
    qry_peer = 5'd3;
    send_msg(64'd3, 1'b1, 0);
    send_msg(64'd3, 1'b1, 0);
    check("R8 limit1 fail", setup_fail, 1);
    check("R8 limit1 code", last_code, 6);
    check("R8 limit1 count", qry_count, 1);

    finished = 1;
    summary();
    $finish;
  end

endmodule